// File: doc/BRIEF.md
# Two-Zeros-in-Three Sequence Detector

This block watches a serial stream that arrives one bit per clock, qualified by a valid strobe. For every accepted bit, it asks one question: do the newest bit and the two accepted bits before it contain exactly two zeros? The answer is given on the same cycle as the bit. Windows overlap, so every accepted bit starts a new evaluation, and back-to-back hits are possible.

Internally, an explicit state machine holds the history. Start-up states cover the period before two bits have been collected. After that, four history states record the last two accepted bits. The output is a Mealy function of the current state and the incoming bit.

A parameter selects how the state is stored:
- a dense three-bit code in which related states sit one bit apart, or
- a one-hot vector.

Both choices give the same behaviour at the ports. Reset is synchronous and active high, and it returns the machine to its empty start-up state.

Top module: `zero_pair_window_det`

## Requirements
- R1: `hit` is a combinational function of the current state, `bit_valid` and `bit_in`, shown in the same cycle as the bit. It is 0 whenever `bit_valid` is 0.
- R2: The first and second valid bits accepted after reset never raise `hit`. The third valid bit is the first that can.
- R3: Once two valid bits have been accepted since reset, a valid bit raises `hit` exactly when the count of 0 values among {second-previous accepted bit, previous accepted bit, `bit_in`} equals two. The patterns 001, 010 and 100 give 1. The patterns 000, 011, 101, 110 and 111 give 0.
- R4: Windows overlap. Every valid bit is evaluated against the two accepted bits before it, so consecutive valid bits can each raise `hit` (for example, the stream 0,0,1,0 hits on its third and fourth bits).
- R5: A cycle with `bit_valid` at 0 neither updates the history nor counts toward start-up, whatever `bit_in` carries.
- R6: A rising clock edge with `rst` at 1 clears the history. The next two valid bits then behave as R2 requires, even if the old history would have produced a hit.
- R7: `hit` is 0 in any cycle in which `rst` is 1, and reset takes priority over `bit_valid` at the clock edge.
- R8: The dense-code variant (`ONE_HOT`=0) and the one-hot variant (`ONE_HOT`=1) produce identical `hit` sequences for the same input stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_valid | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Serial data bit |
| hit | output | 1 | Exactly two of the last three accepted bits are 0 |

## Verification
The bench targets several corners, each tied to a specific failure:
- **Start-up states.** A design whose start-up states leaked history, or whose counting was off by one, would fire on the second bit.
- **Three zeros.** A detector that tests for "at least two zeros" would fire on 000.
- **Idle cycles with toggling data.** A machine that advanced on invalid cycles would shift a wrong bit into its history.
- **Reset in the middle of a history of 00.** A reset that failed to clear the history would then fire on an immediate 1.

Beyond these corners, a long random stream with sparse valid strobes is compared against a three-bit shift-register model. Both storage variants run side by side, which exposes any code that is mapped to the wrong state.

// File: rtl/zd_pkg.sv
package zd_pkg;

    // Logical states: two start-up states after the empty one, then
    // four history states named by the last two accepted bits (older first).
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ONE  = 3'd1,
        ST_ZERO = 3'd2,
        ST_H11  = 3'd3,
        ST_H01  = 3'd4,
        ST_H10  = 3'd5,
        ST_H00  = 3'd6
    } zd_state_e;

    localparam int ZD_NUM_STATES = 7;
    localparam int ZD_DENSE_W    = 3;

    // Dense storage code: successors of the same state differ in one bit,
    // and history states sharing a successor pair are neighbours.
    function automatic logic [ZD_DENSE_W-1:0] zd_dense_code(zd_state_e s);
        logic [ZD_DENSE_W-1:0] c;
        case (s)
            ST_ONE:  c = 3'b010;
            ST_ZERO: c = 3'b011;
            ST_H11:  c = 3'b100;
            ST_H01:  c = 3'b101;
            ST_H10:  c = 3'b110;
            ST_H00:  c = 3'b111;
            default: c = 3'b000;
        endcase
        return c;
    endfunction

    function automatic zd_state_e zd_dense_decode(logic [ZD_DENSE_W-1:0] c);
        zd_state_e s;
        case (c)
            3'b010:  s = ST_ONE;
            3'b011:  s = ST_ZERO;
            3'b100:  s = ST_H11;
            3'b101:  s = ST_H01;
            3'b110:  s = ST_H10;
            3'b111:  s = ST_H00;
            default: s = ST_IDLE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/zd_next_state.sv
module zd_next_state
    import zd_pkg::*;
(
    input  zd_state_e cur,
    input  logic      din,
    output zd_state_e nxt,
    output logic      hit_raw
);

    always_comb begin
        nxt     = ST_IDLE;
        hit_raw = 1'b0;
        case (cur)
            ST_IDLE: nxt = din ? ST_ONE : ST_ZERO;
            ST_ONE:  nxt = din ? ST_H11 : ST_H10;
            ST_ZERO: nxt = din ? ST_H01 : ST_H00;
            // history states: one zero already held unless noted
            ST_H11: begin
                nxt     = din ? ST_H11 : ST_H10;
                hit_raw = 1'b0;
            end
            ST_H01: begin
                nxt     = din ? ST_H11 : ST_H10;
                hit_raw = ~din;
            end
            ST_H10: begin
                nxt     = din ? ST_H01 : ST_H00;
                hit_raw = ~din;
            end
            ST_H00: begin
                nxt     = din ? ST_H01 : ST_H00;
                hit_raw = din;
            end
            default: nxt = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/zd_state_reg.sv
module zd_state_reg
    import zd_pkg::*;
#(
    parameter bit ONE_HOT = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  zd_state_e nxt,
    output zd_state_e cur
);

    generate
        if (ONE_HOT) begin : g_onehot
            localparam int W = ZD_NUM_STATES;
            logic [W-1:0] vec_d, vec_q;

            always_comb begin
                vec_d = vec_q;
                if (rst) begin
                    vec_d = '0;
                    vec_d[int'(ST_IDLE)] = 1'b1;
                end else if (load) begin
                    vec_d = '0;
                    vec_d[int'(nxt)] = 1'b1;
                end
            end

            always_ff @(posedge clk) begin
                vec_q <= vec_d;
            end

            // Any vector that is not exactly one-hot decodes to IDLE.
            always_comb begin
                int unsigned ones;
                zd_state_e   pick;
                ones = 0;
                pick = ST_IDLE;
                for (int i = 0; i < W; i++) begin
                    if (vec_q[i] == 1'b1) begin
                        ones = ones + 1;
                        pick = zd_state_e'(3'(i));
                    end
                end
                cur = (ones == 1) ? pick : ST_IDLE;
            end
        end else begin : g_dense
            logic [ZD_DENSE_W-1:0] code_d, code_q;

            always_comb begin
                code_d = code_q;
                if (rst) begin
                    code_d = zd_dense_code(ST_IDLE);
                end else if (load) begin
                    code_d = zd_dense_code(nxt);
                end
            end

            always_ff @(posedge clk) begin
                code_q <= code_d;
            end

            assign cur = zd_dense_decode(code_q);
        end
    endgenerate

endmodule

// File: rtl/zero_pair_window_det.sv
module zero_pair_window_det
    import zd_pkg::*;
#(
    parameter bit ONE_HOT = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_valid,
    input  logic bit_in,
    output logic hit
);

    zd_state_e cur_state;
    zd_state_e nxt_state;
    logic      hit_raw;

    zd_next_state u_next (
        .cur     (cur_state),
        .din     (bit_in),
        .nxt     (nxt_state),
        .hit_raw (hit_raw)
    );

    zd_state_reg #(
        .ONE_HOT (ONE_HOT)
    ) u_reg (
        .clk  (clk),
        .rst  (rst),
        .load (bit_valid),
        .nxt  (nxt_state),
        .cur  (cur_state)
    );

    // Mealy output, qualified by the strobe and suppressed during reset.
    assign hit = bit_valid & ~rst & hit_raw;

endmodule

// File: rtl/zd_checker.sv
module zd_checker
    import zd_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      bit_valid,
    input logic      bit_in,
    input logic      hit,
    input zd_state_e cur_state
);

    // Independent history model: accepted-bit count (saturating) and last two bits.
    logic [1:0] seen_d, seen_q;
    logic [1:0] hist_d, hist_q;

    always_comb begin
        seen_d = seen_q;
        hist_d = hist_q;
        if (rst) begin
            seen_d = 2'd0;
            hist_d = 2'b11;
        end else if (bit_valid) begin
            hist_d = {hist_q[0], bit_in};
            if (seen_q != 2'd2) seen_d = seen_q + 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        seen_q <= seen_d;
        hist_q <= hist_d;
    end

    a_r1_hit_needs_valid: assert property (@(posedge clk) disable iff (rst)
        hit |-> bit_valid);

    a_r2_no_early_hit: assert property (@(posedge clk) disable iff (rst)
        hit |-> (seen_q == 2'd2));

    // R3 and R4: every accepted bit after start-up is judged against its own window.
    a_r3_window_match: assert property (@(posedge clk) disable iff (rst)
        (bit_valid && seen_q == 2'd2) |-> (hit == ($countones({~hist_q, ~bit_in}) == 2)));

    a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !bit_valid |=> $stable(cur_state));

    a_r6_reset_to_idle: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cur_state == ST_IDLE));

    always_comb begin
        if (rst) a_r7_quiet_in_reset: assert (hit == 1'b0);
    end

endmodule

bind zero_pair_window_det zd_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .bit_valid (bit_valid),
    .bit_in    (bit_in),
    .hit       (hit),
    .cur_state (cur_state)
);

// File: tb/tb_zero_pair_window_det.sv
module tb_zero_pair_window_det;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_valid = 1'b0;
    logic bit_in = 1'b0;
    logic hit, hit_oh;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    zero_pair_window_det #(.ONE_HOT(1'b0)) dut (
        .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in), .hit(hit));

    zero_pair_window_det #(.ONE_HOT(1'b1)) dut_oh (
        .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in), .hit(hit_oh));

    // Vector entry: {rst, bit_valid, bit_in, expected hit}
    localparam int NVEC = 19;
    localparam logic [3:0] VEC [NVEC] = '{
        4'b1000, // R7 reset, idle
        4'b1100, // R7 valid during reset: quiet, no effect
        4'b0100, // R2 first bit 0
        4'b0100, // R2 second bit 0
        4'b0111, // R3 window 001
        4'b0101, // R4 overlap, window 010
        4'b0010, // R5 idle, data 1 ignored
        4'b0000, // R5 idle, data 0 ignored
        4'b0101, // R3 window 100
        4'b0100, // R3 window 000 -> no hit
        4'b0111, // R3 window 001
        4'b0110, // R3 window 011
        4'b0110, // R3 window 111
        4'b0100, // R3 window 110
        4'b0101, // R3 window 100
        4'b1110, // R7 reset over a would-be hit
        4'b0100, // R6 first bit after reset
        4'b0110, // R6 second bit after reset
        4'b0101  // R3 window 010 after reset
    };

    task automatic check(input logic got, input logic exp, input string req);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: hit=%b expected=%b at %0t", req, got, exp, $time);
        end
    endtask

    // Drive after the falling edge, sample mid-low phase, then let the rising edge land.
    task automatic step(input logic r, input logic v, input logic b,
                        input logic exp, input string req);
        @(negedge clk);
        rst = r; bit_valid = v; bit_in = b;
        #5;
        check(hit, exp, req);
        check(hit_oh, exp, "R8");
    endtask

    // Bench reference: saturating count and last two accepted bits.
    logic [1:0] m_hist = 2'b11;
    int         m_seen = 0;

    function automatic logic model_hit(input logic r, input logic v, input logic b);
        int zeros;
        zeros = (m_hist[1] ? 0 : 1) + (m_hist[0] ? 0 : 1) + (b ? 0 : 1);
        return !r && v && (m_seen >= 2) && (zeros == 2);
    endfunction

    function automatic void model_clock(input logic r, input logic v, input logic b);
        if (r) begin
            m_seen = 0;
            m_hist = 2'b11;
        end else if (v) begin
            m_hist = {m_hist[0], b};
            if (m_seen < 2) m_seen++;
        end
    endfunction

    initial begin
        #2_000_000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // Reset state
        @(negedge clk); #5;
        check(hit, 1'b0, "R7");
        @(negedge clk); #5;
        check(hit, 1'b0, "R7");

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0], "R3/table");
        end

        // R2: ones only, start-up then steady: never hits (111)
        step(1'b1, 1'b0, 1'b0, 1'b0, "R7");
        for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 1'b1, 1'b0, "R2");

        // R5: long idle with toggling data between two zeros and a one
        step(1'b0, 1'b1, 1'b0, 1'b0, "R3");      // window 110
        for (int i = 0; i < 8; i++) step(1'b0, 1'b0, i[0], 1'b0, "R5");
        step(1'b0, 1'b1, 1'b0, 1'b1, "R5");      // window 100 only if idle ignored
        step(1'b0, 1'b1, 1'b1, 1'b1, "R4");      // window 001

        // R6: history 00, reset, then an immediate 1 must not hit
        step(1'b0, 1'b1, 1'b0, 1'b1, "R3");      // window 010
        step(1'b0, 1'b1, 1'b0, 1'b1, "R3");      // window 100
        step(1'b1, 1'b0, 1'b0, 1'b0, "R6");
        step(1'b0, 1'b1, 1'b1, 1'b0, "R6");
        step(1'b0, 1'b1, 1'b0, 1'b0, "R6");
        step(1'b0, 1'b1, 1'b0, 1'b1, "R6");      // window 100

        // Random stream against the shift-register model (R1, R3, R4, R8)
        @(negedge clk);
        rst = 1'b1; bit_valid = 1'b0;
        #5;
        model_clock(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 4000; i++) begin
            logic r, v, b;
            r = ($urandom_range(0, 199) == 0);
            v = ($urandom_range(0, 3) != 0);
            b = $urandom_range(0, 1) != 0;
            step(r, v, b, model_hit(r, v, b), "R3/random");
            model_clock(r, v, b);
        end

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule